// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Register Slave

This block sits between a two-wire serial bus (SCL/SDA) and a small bank of byte registers. It oversamples both bus lines with the system clock and removes pulses narrower than a set number of samples. From the cleaned lines it recognises START, repeated START and STOP. It turns each transaction into one-cycle register strobes that present a register index and the byte that goes with it. SDA is open-drain: the block only pulls the line low through `sda_oe` and never drives it high.

The device address has seven bits. The upper five are fixed at `01010` and the lower two come from `pin_sel`, so four of these slaves can share one bus. In a write, the first byte after the address byte loads a register-index counter, and every byte after that is data. A read takes no index byte. It returns data starting at the current counter value, so a master selects a register with an index-only write, then a repeated START and a read. Each write transaction is tagged as it closes, with whether it ended on STOP or on a repeated START. A `busy` input makes the slave refuse its own address. A master can use this to poll until a slow commit of the last write has finished.

Top module: `i2c_reg_slave`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sda_oe`, `reg_wr_en`, `reg_rd_en` and `wr_end_valid` are low, and the index counter resets to 0.
- R2: The slave acknowledges (pulls SDA low in the ninth clock) an address byte whose upper seven bits equal `0,1,0,1,0,pin_sel[1],pin_sel[0]` (MSB first). Bit 0 selects the direction: 0 is write, 1 is read. With `pin_sel`=00 the write byte is 0x50; with `pin_sel`=10 it is 0x54. Any other address byte is not acknowledged.
- R3: In a write, the second byte is acknowledged and loads the index counter. Each later byte to a mapped index (`reg_hit` high) is acknowledged and produces one `reg_wr_en` pulse carrying that index on `reg_addr` and the byte on `reg_wdata`.
- R4: The index counter advances by one after each data byte is written or fetched for a read, so a transfer of several bytes walks consecutive indices.
- R5: A read byte comes from the current index and is sent MSB first. Each bit is placed on SDA only while SCL is low, after the falling edge. A master ACK (0 in the ninth bit) makes the slave send the next byte. A NACK (1) ends the read and leaves SDA released.
- R6: A data byte written while `reg_hit` is low is not acknowledged and produces no strobe. A read byte fetched while `reg_hit` is low is 0x00.
- R7: While `busy` is high at the address decision, the slave does not acknowledge even its own address, and no strobe follows.
- R8: Every write transaction whose address was acknowledged produces exactly one `wr_end_valid` pulse when it closes. `wr_end_stop` is 1 if it closed on STOP and 0 if it closed on a repeated START.
- R9: A pulse on SCL or SDA lasting fewer than `FILT_CYCLES` clock samples has no effect on the protocol.
- R10: After an address byte that is not acknowledged, the slave ignores every bit until the next START, including a byte equal to its own address.
- R11: SDA is released (`sda_oe` low) in the cycle after a STOP is recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| pin_sel | input | 2 | Strap value for the two low device-address bits |
| busy | input | 1 | High while a commit is in progress; refuses the address |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | ADDR_W | Current register index (counter) |
| reg_hit | input | 1 | 1 when `reg_addr` names a mapped register |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to be written with `reg_wr_en` |
| reg_rd_en | output | 1 | One-cycle pulse after a read byte has been fetched |
| wr_end_valid | output | 1 | One-cycle pulse when a write transaction closes |
| wr_end_stop | output | 1 | With `wr_end_valid`: 1 for STOP, 0 for repeated START |

## Verification
At a repeated START, two things happen in the same cycle: the write that is still open is closed and tagged, and a fresh address phase begins. The bench provokes this with an index-only write followed at once by a repeated START and a read. It then expects the closing tag to read "repeated START" and the read address to be acknowledged. It also expects the returned bytes to match the index that the closed write had loaded. The address decision is the other point where two inputs meet. There the bench raises `busy` against a correct address and requires a NACK, with no strobe after it.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int          BYTE_W     = 8;
    localparam logic [4:0]  DEV_PREFIX = 5'b01010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_REG,
        S_WR,
        S_RD,
        S_SKIP
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b, input logic [1:0] pins);
        return b[BYTE_W-1:1] == {DEV_PREFIX, pins};
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            clean  <= 1'b1;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] != clean) begin
                if (run_q == CW'(FILT_CYCLES - 1)) begin
                    clean <= sync_q[1];
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_slv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.start = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop  = scl_f & scl_q & ~sda_q & sda_f;
        evt.rise  = scl_f & ~scl_q;
        evt.fall  = ~scl_f & scl_q;
    end
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
    import i2c_slv_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              sda_f,
    input  logic [1:0]        pin_sel,
    input  logic              busy,
    input  logic              reg_hit,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    output logic              sda_oe,
    output logic              wr_end_valid,
    output logic              wr_end_stop
);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
    localparam logic [3:0] END_SLOT = 4'(BYTE_W + 1);

    slv_state_e        st;
    logic [3:0]        bit_idx;
    logic [BYTE_W-1:0] shreg, tx_q, tx_byte;
    logic              rw_q, wr_txn, mack;
    logic              active;

    assign tx_byte = reg_hit ? reg_rdata : '0;
    assign active  = (st != S_IDLE) && (st != S_SKIP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            bit_idx      <= '0;
            shreg        <= '0;
            tx_q         <= '0;
            rw_q         <= 1'b0;
            wr_txn       <= 1'b0;
            mack         <= 1'b0;
            reg_addr     <= '0;
            reg_wr_en    <= 1'b0;
            reg_wdata    <= '0;
            reg_rd_en    <= 1'b0;
            sda_oe       <= 1'b0;
            wr_end_valid <= 1'b0;
            wr_end_stop  <= 1'b0;
        end else begin
            reg_wr_en    <= 1'b0;
            reg_rd_en    <= 1'b0;
            wr_end_valid <= 1'b0;
            if (evt.start || evt.stop) begin
                if (wr_txn) begin
                    wr_end_valid <= 1'b1;
                    wr_end_stop  <= evt.stop;
                end
                wr_txn  <= 1'b0;
                sda_oe  <= 1'b0;
                bit_idx <= '0;
                st      <= evt.start ? S_DEV : S_IDLE;
            end else if (evt.rise && active) begin
                if (bit_idx < ACK_SLOT) begin
                    shreg <= {shreg[BYTE_W-2:0], sda_f};
                end else if (st == S_RD) begin
                    mack <= ~sda_f;
                end
                bit_idx <= bit_idx + 1'b1;
            end else if (evt.fall && active) begin
                if (bit_idx == ACK_SLOT) begin
                    case (st)
                        S_DEV: begin
                            if (dev_match(shreg, pin_sel) && !busy) begin
                                sda_oe <= 1'b1;
                                rw_q   <= shreg[0];
                                wr_txn <= ~shreg[0];
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= S_SKIP;
                            end
                        end
                        S_REG: begin
                            sda_oe   <= 1'b1;
                            reg_addr <= ADDR_W'(shreg);
                        end
                        S_WR: begin
                            if (reg_hit) begin
                                sda_oe    <= 1'b1;
                                reg_wr_en <= 1'b1;
                                reg_wdata <= shreg;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (bit_idx == END_SLOT) begin
                    bit_idx <= '0;
                    sda_oe  <= 1'b0;
                    case (st)
                        S_DEV: begin
                            if (rw_q) begin
                                st        <= S_RD;
                                tx_q      <= tx_byte;
                                sda_oe    <= ~tx_byte[BYTE_W-1];
                                reg_rd_en <= 1'b1;
                                reg_addr  <= reg_addr + 1'b1;
                            end else begin
                                st <= S_REG;
                            end
                        end
                        S_REG: st <= S_WR;
                        S_WR: begin
                            if (sda_oe) reg_addr <= reg_addr + 1'b1;
                            else        st       <= S_SKIP;
                        end
                        S_RD: begin
                            if (mack) begin
                                tx_q      <= tx_byte;
                                sda_oe    <= ~tx_byte[BYTE_W-1];
                                reg_rd_en <= 1'b1;
                                reg_addr  <= reg_addr + 1'b1;
                            end else begin
                                st <= S_SKIP;
                            end
                        end
                        default: st <= S_SKIP;
                    endcase
                end else if (st == S_RD) begin
                    sda_oe <= ~tx_q[3'(BYTE_W - 1 - int'(bit_idx))];
                end
            end
        end
    end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_slv_pkg::*;
#(
    parameter int FILT_CYCLES = 3,
    parameter int ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pin_sel,
    input  logic              busy,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_hit,
    input  logic [7:0]        reg_rdata,
    output logic              reg_wr_en,
    output logic [7:0]        reg_wdata,
    output logic              reg_rd_en,
    output logic              wr_end_valid,
    output logic              wr_end_stop
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines, clean_lines;
    logic             scl_f, sda_f;
    logic             start_det, stop_det;
    bus_evt_t         evt;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_filt
        i2c_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    assign scl_f     = clean_lines[1];
    assign sda_f     = clean_lines[0];
    assign start_det = evt.start;
    assign stop_det  = evt.stop;

    i2c_bus_events u_evt (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .evt  (evt)
    );

    i2c_slv_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .sda_f       (sda_f),
        .pin_sel     (pin_sel),
        .busy        (busy),
        .reg_hit     (reg_hit),
        .reg_rdata   (reg_rdata),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wdata   (reg_wdata),
        .reg_rd_en   (reg_rd_en),
        .sda_oe      (sda_oe),
        .wr_end_valid(wr_end_valid),
        .wr_end_stop (wr_end_stop)
    );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_f,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic reg_wr_en,
    input logic reg_rd_en,
    input logic reg_hit,
    input logic wr_end_valid,
    input logic wr_end_stop
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            AST_RST_QUIET: assert (!sda_oe && !reg_wr_en && !reg_rd_en && !wr_end_valid); // R1
        end
    end

    AST_WR_MAPPED: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> reg_hit); // R6

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f); // R5

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe); // R11

    AST_END_ON_COND: assert property (@(posedge clk) disable iff (rst)
        wr_end_valid |-> $past(start_det || stop_det)); // R8

    AST_END_KIND: assert property (@(posedge clk) disable iff (rst)
        wr_end_valid |-> (wr_end_stop == $past(stop_det))); // R8
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_f       (scl_f),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_oe      (sda_oe),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_hit     (reg_hit),
    .wr_end_valid(wr_end_valid),
    .wr_end_stop (wr_end_stop)
);

// File: tb/test_i2c_reg_slave.sv
`timescale 1ns/1ps
module test_i2c_reg_slave;
    localparam int Q     = 8;
    localparam int SPAN  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pin_sel = 2'b00;
    logic       busy = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic       reg_hit;
    logic [7:0] reg_rdata;
    logic       reg_wr_en;
    logic [7:0] reg_wdata;
    logic       reg_rd_en;
    logic       wr_end_valid;
    logic       wr_end_stop;

    logic [7:0] mem [0:7];
    logic [15:0] exp_wr[$];
    logic        exp_end[$];
    int total = 0;
    int bad   = 0;
    bit glitch_on = 1'b0;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_hit   = (reg_addr < SPAN);
    assign reg_rdata = mem[reg_addr[2:0]];

    always @(posedge clk) if (reg_wr_en) mem[reg_addr[2:0]] <= reg_wdata;

    i2c_reg_slave i_i2c_reg_slave (
        .clk(clk), .rst(rst), .pin_sel(pin_sel), .busy(busy),
        .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_hit(reg_hit), .reg_rdata(reg_rdata),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en),
        .wr_end_valid(wr_end_valid), .wr_end_stop(wr_end_stop)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the expected strobe streams
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr_en) begin
                if (exp_wr.size() == 0) chk(0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
                else begin
                    logic [15:0] e;
                    e = exp_wr.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R3 write strobe", {reg_addr, reg_wdata}, e);
                end
            end
            if (wr_end_valid) begin
                if (exp_end.size() == 0) chk(0, "R8 unexpected end tag", wr_end_stop, 0);
                else begin
                    logic e;
                    e = exp_end.pop_front();
                    chk(wr_end_stop == e, "R8 end tag", wr_end_stop, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1;
        if (glitch_on && b) begin
            tick(3); sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(2*Q-5);
        end else begin
            tick(2*Q);
        end
        scl_m = 1'b0;
        if (glitch_on) begin
            tick(2); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q-4);
        end else begin
            tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            d[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = ~give_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0;
        sda_m = 1'b1; tick(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;
        tick(4);
        chk(sda_oe == 0 && reg_wr_en == 0 && wr_end_valid == 0, "R1 outputs in reset", sda_oe, 0);
        rst = 1'b0;
        tick(2);
        chk(sda_oe == 0 && reg_addr == 0, "R1 state after reset", reg_addr, 0);

        // single write
        exp_wr.push_back({8'h01, 8'hA5}); exp_end.push_back(1'b1);
        bus_start();
        send_byte(8'h50, a); chk(a, "R2 own write address ACK", a, 1);
        send_byte(8'h01, a); chk(a, "R3 index byte ACK", a, 1);
        send_byte(8'hA5, a); chk(a, "R3 data byte ACK", a, 1);
        bus_stop(); tick(2);
        chk(sda_oe == 0, "R11 released after STOP", sda_oe, 0);

        // multi-byte write, counter walk
        exp_wr.push_back({8'h02, 8'h11}); exp_wr.push_back({8'h03, 8'h22}); exp_end.push_back(1'b1);
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h02, a);
        send_byte(8'h11, a); chk(a, "R4 first of burst ACK", a, 1);
        send_byte(8'h22, a); chk(a, "R4 second of burst ACK", a, 1);
        bus_stop();

        // write running into unmapped index
        exp_wr.push_back({8'h03, 8'h33}); exp_end.push_back(1'b1);
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h03, a);
        send_byte(8'h33, a); chk(a, "R6 mapped byte ACK", a, 1);
        send_byte(8'h44, a); chk(!a, "R6 unmapped byte NACK", a, 0);
        bus_stop();

        // index-only write, repeated START, read two bytes
        exp_end.push_back(1'b0);
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h02, a);
        bus_start();
        send_byte(8'h51, a); chk(a, "R2 own read address ACK", a, 1);
        recv_byte(1'b1, d); chk(d == 8'h11, "R5 read byte at index 2", d, 8'h11);
        recv_byte(1'b0, d); chk(d == 8'h33, "R5 read byte at index 3", d, 8'h33);
        chk(sda_oe == 0, "R5 SDA released after master NACK", sda_oe, 0);
        bus_stop();

        // read with no index byte: counter is now 4, unmapped
        bus_start();
        send_byte(8'h51, a);
        recv_byte(1'b0, d); chk(d == 8'h00, "R6 unmapped read gives zero (R4 counter kept)", d, 0);
        bus_stop();

        // wrong address, then own address without START
        bus_start();
        send_byte(8'h52, a); chk(!a, "R2 foreign address NACK", a, 0);
        send_byte(8'h50, a); chk(!a, "R10 own address ignored without START", a, 0);
        send_byte(8'h00, a); chk(!a, "R10 later byte ignored", a, 0);
        bus_stop();

        // busy refuses own address
        busy = 1'b1;
        bus_start();
        send_byte(8'h50, a); chk(!a, "R7 address NACK while busy", a, 0);
        send_byte(8'h00, a);
        send_byte(8'h77, a); chk(!a, "R7 no data accepted while busy", a, 0);
        bus_stop();
        busy = 1'b0;

        // strap change
        pin_sel = 2'b10;
        tick(4);
        bus_start();
        send_byte(8'h50, a); chk(!a, "R2 old address NACK after strap change", a, 0);
        bus_stop();
        exp_wr.push_back({8'h00, 8'h5C}); exp_end.push_back(1'b1);
        bus_start();
        send_byte(8'h54, a); chk(a, "R2 strapped address ACK", a, 1);
        send_byte(8'h00, a);
        send_byte(8'h5C, a);
        bus_stop();

        // glitches on both lines
        glitch_on = 1'b1;
        exp_wr.push_back({8'h01, 8'hC3}); exp_end.push_back(1'b1);
        bus_start();
        send_byte(8'h54, a); chk(a, "R9 address ACK under glitches", a, 1);
        send_byte(8'h01, a);
        send_byte(8'hC3, a); chk(a, "R9 data ACK under glitches", a, 1);
        bus_stop();
        glitch_on = 1'b0;

        exp_end.push_back(1'b0);
        bus_start();
        send_byte(8'h54, a);
        send_byte(8'h01, a);
        bus_start();
        send_byte(8'h55, a);
        recv_byte(1'b0, d); chk(d == 8'hC3, "R9 glitched write landed intact", d, 8'hC3);
        bus_stop();
        tick(20);

        chk(exp_wr.size() == 0, "R3 all expected writes seen", exp_wr.size(), 0);
        chk(exp_end.size() == 0, "R8 all expected end tags seen", exp_end.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule